// File: doc/BRIEF.md
# GPIO Interrupt Slot Router

This block takes a wide bus of GPIO interrupt request lines and maps up to 32 of them onto 32 interrupt slots. Each slot has an 8-bit selector byte. Bit 7 of that byte turns the slot on, and the low 7 bits pick one line of the GPIO bus. A 2-bit trigger code tells the slot to detect a rising edge, a falling edge, a high level or a low level on that line. When the trigger condition holds, the slot's sticky status bit is set. Each status bit drives its own active-high interrupt output, which goes to a parent interrupt controller.

Software controls the block through a simple 32-bit register port. A write is a single-cycle strobe with an address and a data word. Reads are combinational from the address. The selector bytes are packed four to a word. The trigger codes are packed sixteen to a word. Software acknowledges an interrupt by writing 0 to that slot's status bit. Any hardware set in the same cycle takes priority over the clear.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every slot output is low, and every register reads 0: all slots off, trigger code 0, status clear.
- R2: Slot k's selector byte is at byte lane k%4 of the word at offset 0x30+4*(k/4). Bit 7 of the byte is the enable and bits 6:0 are the source index. The byte reads back as written.
- R3: Slot k's 2-bit trigger code is at bits 2*(k%16)+1:2*(k%16). Slots 0-15 use offset 0x24 and slots 16-31 use offset 0x28. An address that is not mapped reads 0, and a write to it changes no register.
- R4: A slot watches only the GPIO line whose number equals its 7-bit source index. Indices at or above the bus width read as 0.
- R5: Trigger code 0 (rising): a 0-to-1 change on the source sets the status bit at the clock edge that samples the 1. The output is high from that edge on, and not before it.
- R6: Trigger code 1 (falling): a 1-to-0 change sets the status bit. A rising change does not set it.
- R7: Trigger codes 2 (high level) and 3 (low level): the status bit is set at every clock edge at which the source is at the selected level.
- R8: A status bit stays set until software writes 0 to its position at offset 0x20. Writing 1 there leaves the bit as it was.
- R9: If a set condition and a software clear of the same status bit happen at the same clock edge, the bit ends up set.
- R10: A slot whose enable bit is 0 never sets its status bit. A slot that has just been enabled takes its first sample as history and does not detect an edge on that sample.
- R11: Slot output k always equals status bit k, and status bit k reads back at bit k of offset 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_irq_i | input | GPIO_W | GPIO interrupt request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| slot_irq_o | output | NUM_SLOTS | Per-slot active-high interrupt level |

## Verification
Each slot registers its detection result exactly once. A GPIO change or a register write applied before a rising clock edge therefore shows up on the slot outputs and in the status word right after that edge. Register readback is combinational and appears in the same cycle as the address. The bench drives its inputs on the falling edge. It checks that a new edge has not yet produced an output before the next rising edge, and it checks the effect at the following falling edge. A behavioural model advances on each rising edge and is compared with the outputs at every falling edge. This means a result that arrives a cycle early or a cycle late is reported.

// File: rtl/girq_pkg.sv
package girq_pkg;
    localparam int REG_W        = 32;
    localparam int SEL_W        = 8;
    localparam int IDX_W        = SEL_W - 1;
    localparam int MODE_W       = 2;
    localparam int SEL_PER_REG  = REG_W / SEL_W;
    localparam int MODE_PER_REG = REG_W / MODE_W;
    localparam int STAT_OFS     = 'h20;
    localparam int MODE_OFS     = 'h24;
    localparam int SEL_OFS      = 'h30;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;
endpackage

// File: rtl/girq_slot.sv
module girq_slot
    import girq_pkg::*;
#(
    parameter int GPIO_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] gpio_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  trig_e             trig_i,
    output logic              hit_o
);
    // The source index addresses a zero-padded copy of the bus (GPIO_W <= 2**IDX_W).
    localparam int PAD_W = 1 << IDX_W;

    typedef struct packed {
        logic armed;
        logic prev;
    } slot_st_t;

    slot_st_t         st_q, st_d;
    logic [PAD_W-1:0] gpio_pad;
    logic             enable;
    logic             cur;

    always_comb begin
        gpio_pad               = '0;
        gpio_pad[GPIO_W-1:0]   = gpio_i;
        enable                 = sel_i[SEL_W-1];
        cur                    = gpio_pad[sel_i[IDX_W-1:0]];
        st_d                   = st_q;
        hit_o                  = 1'b0;
        if (!enable) begin
            // History stays frozen while the slot is off.
            st_d.armed = 1'b0;
        end else begin
            unique case (trig_i)
                TRIG_RISE: hit_o = st_q.armed & ~st_q.prev & cur;
                TRIG_FALL: hit_o = st_q.armed & st_q.prev & ~cur;
                TRIG_HIGH: hit_o = cur;
                TRIG_LOW:  hit_o = ~cur;
            endcase
            st_d.armed = 1'b1;
            st_d.prev  = cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: the first enabled sample only loads history in edge modes
    a_r10_no_edge_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable) && (trig_i == TRIG_RISE || trig_i == TRIG_FALL)) |-> !hit_o);

    // R5: a rising hit needs a low sample one cycle earlier
    a_r5_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && trig_i == TRIG_RISE) |-> (cur && !$past(cur)));

    // R6: a falling hit needs a high sample one cycle earlier
    a_r6_fall_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && trig_i == TRIG_FALL) |-> (!cur && $past(cur)));
endmodule

// File: rtl/girq_regs.sv
module girq_regs
    import girq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [REG_W-1:0]               wdata_i,
    input  logic [NUM_SLOTS-1:0]           status_i,
    output logic [REG_W-1:0]               rdata_o,
    output logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_o,
    output trig_e [NUM_SLOTS-1:0]          trig_o,
    output logic                           stat_wr_o
);
    localparam int N_SEL_REGS  = (NUM_SLOTS + SEL_PER_REG - 1) / SEL_PER_REG;
    localparam int N_MODE_REGS = (NUM_SLOTS + MODE_PER_REG - 1) / MODE_PER_REG;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SEL_W-1:0] sel;
        trig_e [NUM_SLOTS-1:0]           trig;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic addr_hit;

    always_comb begin
        cfg_d     = cfg_q;
        rdata_o   = '0;
        addr_hit  = (addr_i == ADDR_W'(STAT_OFS));
        stat_wr_o = wr_i && (addr_i == ADDR_W'(STAT_OFS));
        if (addr_i == ADDR_W'(STAT_OFS)) rdata_o[NUM_SLOTS-1:0] = status_i;
        for (int r = 0; r < N_SEL_REGS; r++)
            if (addr_i == ADDR_W'(SEL_OFS + 4 * r)) addr_hit = 1'b1;
        for (int r = 0; r < N_MODE_REGS; r++)
            if (addr_i == ADDR_W'(MODE_OFS + 4 * r)) addr_hit = 1'b1;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (addr_i == ADDR_W'(SEL_OFS + 4 * (k / SEL_PER_REG))) begin
                rdata_o[SEL_W*(k%SEL_PER_REG) +: SEL_W] = cfg_q.sel[k];
                if (wr_i) cfg_d.sel[k] = wdata_i[SEL_W*(k%SEL_PER_REG) +: SEL_W];
            end
            if (addr_i == ADDR_W'(MODE_OFS + 4 * (k / MODE_PER_REG))) begin
                rdata_o[MODE_W*(k%MODE_PER_REG) +: MODE_W] = cfg_q.trig[k];
                if (wr_i) cfg_d.trig[k] = trig_e'(wdata_i[MODE_W*(k%MODE_PER_REG) +: MODE_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel_o  = cfg_q.sel;
    assign trig_o = cfg_q.trig;

    // R3: writes to unmapped addresses leave the configuration alone
    a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_hit) |=> $stable(cfg_q));

    // R3: an unmapped address always reads as zero
    a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import girq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int GPIO_W    = 128,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GPIO_W-1:0]    gpio_irq_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic [NUM_SLOTS-1:0] slot_irq_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] status;
    } stat_t;

    stat_t                           st_q, st_d;
    logic [NUM_SLOTS-1:0]            hit;
    logic [NUM_SLOTS-1:0][SEL_W-1:0] sel;
    trig_e [NUM_SLOTS-1:0]           trig;
    logic                            stat_wr;

    girq_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .status_i  (st_q.status),
        .rdata_o   (reg_rdata_o),
        .sel_o     (sel),
        .trig_o    (trig),
        .stat_wr_o (stat_wr)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        girq_slot #(
            .GPIO_W (GPIO_W)
        ) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .gpio_i (gpio_irq_i),
            .sel_i  (sel[k]),
            .trig_i (trig[k]),
            .hit_o  (hit[k])
        );

        // R8: a set bit survives unless its clear position is written with 0
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.status[k] && !(stat_wr && !reg_wdata_i[k])) |=> st_q.status[k]);

        // R8: a clear with no set pending drops the bit
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && !reg_wdata_i[k] && !hit[k]) |=> !st_q.status[k]);

        // R9: set beats a simultaneous clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> st_q.status[k]);

        // R10: a status bit only rises for a slot enabled in the prior cycle
        a_r10_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.status[k]) |-> $past(sel[k][SEL_W-1]));
    end

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.status = (st_q.status & reg_wdata_i[NUM_SLOTS-1:0]) | hit;
        else         st_d.status = st_q.status | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_irq_o = st_q.status;
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb_top;
    localparam int NS = 32;
    localparam int GW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [GW-1:0] gpio = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NS-1:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_router #(.NUM_SLOTS(NS), .GPIO_W(GW), .ADDR_W(8)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpio_irq_i  (gpio),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .slot_irq_o  (irq)
    );

    // Behavioural reference: per-slot settings and history kept in plain arrays
    bit [7:0]  m_sel [NS];
    bit [1:0]  m_code[NS];
    bit        m_last[NS];
    bit        m_live[NS];
    bit [31:0] m_stat;

    always @(posedge clk) begin
        bit [31:0] fired;
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_sel[k] = 0; m_code[k] = 0; m_last[k] = 0; m_live[k] = 0;
            end
            m_stat = 0;
        end else begin
            fired = 0;
            for (int k = 0; k < NS; k++) begin
                bit v;
                v = gpio[m_sel[k][6:0]];
                if (m_sel[k][7]) begin
                    if (m_code[k] == 0 && m_live[k] && !m_last[k] && v) fired[k] = 1;
                    if (m_code[k] == 1 && m_live[k] && m_last[k] && !v) fired[k] = 1;
                    if (m_code[k] == 2 && v) fired[k] = 1;
                    if (m_code[k] == 3 && !v) fired[k] = 1;
                    m_last[k] = v;
                    m_live[k] = 1;
                end else begin
                    m_live[k] = 0;
                end
            end
            if (wr && addr == 8'h20) m_stat = (m_stat & wdata) | fired;
            else                     m_stat = m_stat | fired;
            if (wr) begin
                for (int k = 0; k < NS; k++) begin
                    if (addr == 8'h30 + 8'(4 * (k / 4))) m_sel[k]  = wdata[8*(k%4) +: 8];
                    if (addr == 8'h24 + 8'(4 * (k / 16))) m_code[k] = wdata[2*(k%16) +: 2];
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R11: outputs track the reference status every cycle
    always @(negedge clk) begin
        if (rst_n && !done) check("R11 per-cycle output", irq, m_stat);
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic reg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
        addr = 8'h00;
    endtask

    task automatic set_pin(input int idx, input bit v);
        @(negedge clk);
        gpio[idx] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs low", irq, 32'h0);
        reg_check("R1 status zero", 8'h20, 32'h0);
        reg_check("R1 selector zero", 8'h30, 32'h0);
        reg_check("R1 trigger zero", 8'h24, 32'h0);

        // R2: selector packing
        reg_write(8'h30, 32'hFF03_8A83);
        reg_check("R2 selector word 0", 8'h30, 32'hFF03_8A83);
        reg_write(8'h44, 32'h0000_9400);
        reg_check("R2 selector word 5", 8'h44, 32'h0000_9400);
        reg_check("R2 neighbour word", 8'h40, 32'h0);

        // R3: trigger packing and unmapped addresses
        reg_write(8'h24, 32'h0000_0084);
        reg_write(8'h28, 32'h0000_0400);
        reg_check("R3 trigger low half", 8'h24, 32'h0000_0084);
        reg_check("R3 trigger high half", 8'h28, 32'h0000_0400);
        reg_write(8'h2C, 32'hFFFF_FFFF);
        reg_check("R3 unmapped reads 0", 8'h2C, 32'h0);
        reg_check("R3 unmapped write ignored", 8'h30, 32'hFF03_8A83);

        // R5: rising edge on line 3 -> slot 0
        set_pin(3, 1'b1);
        #1 check("R5 not before edge", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        check("R5 rising sets", {31'h0, irq[0]}, 32'h1);
        check("R10 disabled slot 2 quiet", {31'h0, irq[2]}, 32'h0);
        check("R4 slot 1 ignores line 3", {31'h0, irq[1]}, 32'h0);
        set_pin(3, 1'b0);
        @(negedge clk);
        check("R8 sticky after drop", {31'h0, irq[0]}, 32'h1);
        reg_write(8'h20, 32'hFFFF_FFFF);
        check("R8 write 1 keeps", {31'h0, irq[0]}, 32'h1);
        reg_write(8'h20, 32'hFFFF_FFFE);
        check("R8 write 0 clears", {31'h0, irq[0]}, 32'h0);

        // R6: falling edge on line 10 -> slot 1
        set_pin(10, 1'b1);
        @(negedge clk);
        check("R6 rising ignored", {31'h0, irq[1]}, 32'h0);
        set_pin(10, 1'b0);
        @(negedge clk);
        check("R6 falling sets", {31'h0, irq[1]}, 32'h1);
        reg_check("R11 status readback", 8'h20, 32'h0000_0002);
        reg_write(8'h20, 32'h0);

        // R7 / R9: high level on line 127 -> slot 3
        set_pin(127, 1'b1);
        @(negedge clk);
        check("R7 high level sets", {31'h0, irq[3]}, 32'h1);
        reg_write(8'h20, 32'h0);
        check("R9 set beats clear", {31'h0, irq[3]}, 32'h1);
        set_pin(127, 1'b0);
        reg_write(8'h20, 32'h0);
        check("R7 level gone clears", {31'h0, irq[3]}, 32'h0);

        // R10: enable while source already high
        set_pin(3, 1'b1);
        reg_write(8'h20, 32'h0);
        reg_write(8'h30, 32'hFF83_8A83);
        repeat (3) @(negedge clk);
        check("R10 no edge on enable", {31'h0, irq[2]}, 32'h0);
        set_pin(3, 1'b0);
        set_pin(3, 1'b1);
        @(negedge clk);
        check("R10 edge after enable", {31'h0, irq[2]}, 32'h1);

        // R2: slot 21 in lane 1 of word 5, falling on line 20
        set_pin(20, 1'b1);
        set_pin(20, 1'b0);
        @(negedge clk);
        check("R2 slot 21 fires", {31'h0, irq[21]}, 32'h1);
        reg_check("R11 status word", 8'h20, 32'h0020_0005);

        // R10: zeroing the selector disables the slot
        reg_write(8'h44, 32'h0);
        reg_write(8'h20, 32'h0);
        set_pin(20, 1'b1);
        set_pin(20, 1'b0);
        @(negedge clk);
        check("R10 zeroed selector quiet", {31'h0, irq[21]}, 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule